// File: doc/BRIEF.md
# Configuration Image Header Parser

This block reads the header of a configuration image one byte at a time from a valid/ready stream. It works out where the bitstream begins and how many payload bytes the bitstream carries. Every accepted byte is written into an internal byte buffer, so the parser can go back to any earlier offset. Each field is found by following offsets that were read from earlier fields.

The walk has several stages. First a single size byte is read. That byte gives the position of a record count and of a lookup table made of tagged records. Two of the tags point to the bitstream and to a table of component sizes. The component sizes are 22-bit fields packed end to end across byte boundaries, and the block adds them up. When the walk ends, the block raises a one-cycle completion pulse and holds its results. The error flag is held as well.

The block handles one image per reset. Once it finishes, it stops taking bytes until it is reset again.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The header length is the byte at offset 24. The lookup-table record count is the byte at offset (header length − 1). A header length of zero ends the walk with an error.
- R2: Lookup records are 9 bytes each and start at offset (header length). In each record, byte 0 is the tag and bytes 1..4 are a little-endian 32-bit offset.
- R3: Tag 8 gives the bitstream start offset, which appears on `bs_start`. Tag 5 gives the start of the size table. The walk stops at the record where both tags have been seen, so later records are never read.
- R4: If tag 8 or tag 5 is still missing after every record has been read, `error` is raised together with `done`. A record count of zero also gives an error.
- R5: The component count is the little-endian 16-bit value at offsets 55..56. A count of zero gives `data_size` = 0 with no error.
- R6: Component i occupies bits i·22 .. i·22+21 of the size table. Bit k of the table is bit (k mod 8) of byte (k div 8), and the lowest-numbered bit is the least significant. The block reads a 4-byte window starting at byte (i·22 div 8) for each component. `data_size` is 16 times the sum of the component sizes, held in a register wide enough never to wrap.
- R7: If the bitstream start offset or the size-table offset is at or beyond the buffer depth, the walk ends with an error. The offset never wraps into the buffer.
- R8: If any byte the walk needs to read lies at or beyond the buffer depth, the walk ends with an error.
- R9: `done` is high for exactly one cycle. From that cycle on, `in_ready` stays low, and `bs_start`, `data_size` and `error` hold their values until reset. `in_ready` is also low while the buffer is full.
- R10: After reset, `done` and `error` are 0, `in_ready` is 1, and `bs_start` and `data_size` are 0.
- R11: Gaps in `in_valid` only delay the result. When a needed byte has not yet arrived, the walk waits for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Image byte present |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Block takes the byte on this edge |
| bs_start | output | 32 | Bitstream start offset |
| data_size | output | 42 | Bitstream payload size in bytes |
| done | output | 1 | One-cycle pulse at the end of the walk |
| error | output | 1 | Walk failed; held until reset |

## Verification
The bench builds images from a table of lookup layouts and component counts, and packs the component sizes bit by bit from the stated layout. A wrong bit shift or byte index would therefore show up as a wrong `data_size`. It checks a record table whose count runs past the buffer while both tags sit in the first two records. A parser that does not stop early would read out of bounds and raise a false error. It also covers a missing tag, a zero header length, a zero component count, start offsets exactly at and just below the buffer depth, and a record walk that runs off the buffer. An image streamed with gaps must give the same result as an image streamed without them.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned OFF_W       = 32;
    localparam int unsigned LA_W        = OFF_W + 2;
    localparam int unsigned REC_BYTES   = 9;
    localparam int unsigned HLEN_OFF    = 24;
    localparam int unsigned NCOMP_OFF   = 55;
    localparam int unsigned TAG_BITS    = 8;
    localparam int unsigned TAG_SIZES   = 5;
    localparam int unsigned COMP_W      = 22;
    localparam int unsigned NCOMP_W     = 16;
    localparam int unsigned FRAME_SHIFT = 4;
    localparam int unsigned SIZE_W      = NCOMP_W + COMP_W + FRAME_SHIFT;
    localparam int unsigned BITPOS_W    = NCOMP_W + 5;
    localparam int unsigned WORD_W      = 32;

    typedef enum logic [3:0] {
        P_HLEN,
        P_NREC,
        P_REC_TAG,
        P_REC_OFF,
        P_RANGE,
        P_NCOMP,
        P_COMP,
        P_HALT
    } walk_st_e;

    typedef enum logic {
        F_ISSUE,
        F_CAPT
    } fetch_st_e;

    function automatic logic [COMP_W-1:0] comp_field(input logic [WORD_W-1:0] w,
                                                     input logic [2:0] sh);
        logic [WORD_W-1:0] t;
        t = w >> sh;
        return t[COMP_W-1:0];
    endfunction
endpackage

// File: rtl/hdr_byte_buf.sv
module hdr_byte_buf #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [hdr_pkg::BYTE_W-1:0] wr_data,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    output logic [hdr_pkg::BYTE_W-1:0] rd_data,
    output logic [AW:0]               wr_count
);
    logic [hdr_pkg::BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_count[AW-1:0]] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst)        wr_count <= '0;
        else if (wr_en) wr_count <= wr_count + 1'b1;
    end
endmodule

// File: rtl/hdr_fetch.sv
module hdr_fetch #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req,
    input  logic [hdr_pkg::LA_W-1:0]    base,
    input  logic [2:0]                  nbytes,
    input  logic [AW:0]                 wr_count,
    output logic                        rd_en,
    output logic [AW-1:0]               rd_addr,
    input  logic [hdr_pkg::BYTE_W-1:0]  rd_data,
    output logic                        ack,
    output logic                        oob,
    output logic [hdr_pkg::WORD_W-1:0]  value
);
    import hdr_pkg::*;

    fetch_st_e        st;
    logic [1:0]       idx;
    logic [LA_W-1:0]  addr;
    logic             active;
    logic             beyond;
    logic             present;

    assign addr    = base + LA_W'(idx);
    assign active  = (st == F_ISSUE) && req && !ack && !oob;
    assign beyond  = addr >= LA_W'(DEPTH);
    assign present = addr < LA_W'(wr_count);
    assign rd_en   = active && !beyond && present;
    assign rd_addr = addr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= F_ISSUE;
            idx   <= '0;
            ack   <= 1'b0;
            oob   <= 1'b0;
            value <= '0;
        end else begin
            ack <= 1'b0;
            oob <= 1'b0;
            case (st)
                F_ISSUE: begin
                    if (active) begin
                        if (beyond) begin
                            oob <= 1'b1;
                            idx <= '0;
                        end else if (present) begin
                            st <= F_CAPT;
                        end
                    end
                end
                F_CAPT: begin
                    if (idx == 2'd0) value <= {{(WORD_W-BYTE_W){1'b0}}, rd_data};
                    else             value[idx*BYTE_W +: BYTE_W] <= rd_data;
                    st <= F_ISSUE;
                    if ({1'b0, idx} == nbytes - 3'd1) begin
                        ack <= 1'b1;
                        idx <= '0;
                    end else begin
                        idx <= idx + 2'd1;
                    end
                end
                default: st <= F_ISSUE;
            endcase
        end
    end
endmodule

// File: rtl/hdr_comp_acc.sv
module hdr_comp_acc (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            step,
    input  logic [hdr_pkg::WORD_W-1:0]      word,
    output logic [hdr_pkg::BITPOS_W-4:0]    byte_off,
    output logic [hdr_pkg::NCOMP_W-1:0]     index,
    output logic [hdr_pkg::SIZE_W-1:0]      sum
);
    import hdr_pkg::*;

    logic [BITPOS_W-1:0] bitpos;
    logic [COMP_W-1:0]   field;

    assign byte_off = bitpos[BITPOS_W-1:3];
    assign field    = comp_field(word, bitpos[2:0]);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bitpos <= '0;
            index  <= '0;
            sum    <= '0;
        end else if (step) begin
            bitpos <= bitpos + BITPOS_W'(COMP_W);
            index  <= index + 1'b1;
            sum    <= sum + SIZE_W'(field);
        end
    end
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser #(
    parameter int unsigned DEPTH = 1024
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [7:0]                    in_data,
    output logic                          in_ready,
    output logic [31:0]                   bs_start,
    output logic [hdr_pkg::SIZE_W-1:0]    data_size,
    output logic                          done,
    output logic                          error
);
    import hdr_pkg::*;

    localparam int unsigned AW = $clog2(DEPTH);

    walk_st_e              st;
    logic [7:0]            hlen;
    logic [7:0]            rec_left;
    logic [7:0]            cur_tag;
    logic [LA_W-1:0]       rec_base;
    logic [OFF_W-1:0]      bs_off;
    logic [OFF_W-1:0]      tab_off;
    logic                  got_bs;
    logic                  got_tab;
    logic [NCOMP_W-1:0]    ncomp;
    logic                  done_q;
    logic                  err_q;

    logic [AW:0]           wr_count;
    logic                  wr_en;
    logic                  rd_en;
    logic [AW-1:0]         rd_addr;
    logic [BYTE_W-1:0]     rd_data;

    logic                  f_req;
    logic [LA_W-1:0]       f_base;
    logic [2:0]            f_n;
    logic                  f_ack;
    logic                  f_oob;
    logic [WORD_W-1:0]     f_val;

    logic [BITPOS_W-4:0]   c_byte_off;
    logic [NCOMP_W-1:0]    c_index;
    logic [SIZE_W-1:0]     c_sum;
    logic                  c_step;
    logic                  c_clear;

    logic                  tag_is_bs;
    logic                  tag_is_tab;
    logic                  both_seen;
    logic                  range_bad;
    logic                  abort;
    logic                  finish_ok;

    assign wr_en    = in_valid && in_ready;
    assign in_ready = (st != P_HALT) && (wr_count != (AW+1)'(DEPTH));

    hdr_byte_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (in_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_count (wr_count)
    );

    always_comb begin
        f_req  = 1'b1;
        f_base = '0;
        f_n    = 3'd1;
        case (st)
            P_HLEN:    f_base = LA_W'(HLEN_OFF);
            P_NREC:    f_base = LA_W'(hlen) - LA_W'(1);
            P_REC_TAG: f_base = rec_base;
            P_REC_OFF: begin
                f_base = rec_base + LA_W'(1);
                f_n    = 3'd4;
            end
            P_NCOMP: begin
                f_base = LA_W'(NCOMP_OFF);
                f_n    = 3'd2;
            end
            P_COMP: begin
                f_base = LA_W'(tab_off) + LA_W'(c_byte_off);
                f_n    = 3'd4;
            end
            default: f_req = 1'b0;
        endcase
    end

    hdr_fetch #(.DEPTH(DEPTH)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .req      (f_req),
        .base     (f_base),
        .nbytes   (f_n),
        .wr_count (wr_count),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ack      (f_ack),
        .oob      (f_oob),
        .value    (f_val)
    );

    assign c_step  = (st == P_COMP) && f_ack;
    assign c_clear = (st == P_NCOMP) && f_ack;

    hdr_comp_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear    (c_clear),
        .step     (c_step),
        .word     (f_val),
        .byte_off (c_byte_off),
        .index    (c_index),
        .sum      (c_sum)
    );

    assign tag_is_bs  = cur_tag == 8'(TAG_BITS);
    assign tag_is_tab = cur_tag == 8'(TAG_SIZES);
    assign both_seen  = (got_bs || tag_is_bs) && (got_tab || tag_is_tab);
    assign range_bad  = (bs_off >= OFF_W'(DEPTH)) || (tab_off >= OFF_W'(DEPTH));

    always_comb begin
        abort = f_oob && (st != P_HALT);
        case (st)
            P_HLEN:    if (f_ack && f_val[7:0] == 8'd0) abort = 1'b1;
            P_NREC:    if (f_ack && f_val[7:0] == 8'd0) abort = 1'b1;
            P_REC_OFF: if (f_ack && !both_seen && rec_left == 8'd1) abort = 1'b1;
            P_RANGE:   if (range_bad) abort = 1'b1;
            default: ;
        endcase
    end

    assign finish_ok = ((st == P_NCOMP) && f_ack && f_val[NCOMP_W-1:0] == '0) ||
                       ((st == P_COMP) && f_ack && c_index == ncomp - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= P_HLEN;
            hlen     <= '0;
            rec_left <= '0;
            cur_tag  <= '0;
            rec_base <= '0;
            bs_off   <= '0;
            tab_off  <= '0;
            got_bs   <= 1'b0;
            got_tab  <= 1'b0;
            ncomp    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                st     <= P_HALT;
                err_q  <= 1'b1;
                done_q <= 1'b1;
            end else if (finish_ok) begin
                st     <= P_HALT;
                done_q <= 1'b1;
                if (st == P_NCOMP) ncomp <= f_val[NCOMP_W-1:0];
            end else begin
                case (st)
                    P_HLEN: if (f_ack) begin
                        hlen <= f_val[7:0];
                        st   <= P_NREC;
                    end
                    P_NREC: if (f_ack) begin
                        rec_left <= f_val[7:0];
                        rec_base <= LA_W'(hlen);
                        st       <= P_REC_TAG;
                    end
                    P_REC_TAG: if (f_ack) begin
                        cur_tag <= f_val[7:0];
                        st      <= P_REC_OFF;
                    end
                    P_REC_OFF: if (f_ack) begin
                        if (tag_is_bs) begin
                            bs_off <= f_val;
                            got_bs <= 1'b1;
                        end
                        if (tag_is_tab) begin
                            tab_off <= f_val;
                            got_tab <= 1'b1;
                        end
                        if (both_seen) begin
                            st <= P_RANGE;
                        end else begin
                            rec_left <= rec_left - 8'd1;
                            rec_base <= rec_base + LA_W'(REC_BYTES);
                            st       <= P_REC_TAG;
                        end
                    end
                    P_RANGE: st <= P_NCOMP;
                    P_NCOMP: if (f_ack) begin
                        ncomp <= f_val[NCOMP_W-1:0];
                        st    <= P_COMP;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done      = done_q;
    assign error     = err_q;
    assign bs_start  = bs_off;
    assign data_size = c_sum << FRAME_SHIFT;
endmodule

// File: rtl/hdr_parser_chk.sv
module hdr_parser_chk #(
    parameter int unsigned DEPTH = 1024
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_ready,
    input logic                       done,
    input logic                       error,
    input logic [31:0]                bs_start,
    input logic [hdr_pkg::SIZE_W-1:0] data_size
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R9
    AST_NO_INTAKE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);                                        // R9
    AST_ERROR_HELD: assert property (@(posedge clk) disable iff (rst)
        error |=> error);                                           // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(bs_start) && $stable(data_size)));        // R9
    AST_BS_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> (bs_start < 32'(DEPTH)));              // R7
    AST_ERROR_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);                                     // R4
endmodule

bind cfg_hdr_parser hdr_parser_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .done      (done),
    .error     (error),
    .bs_start  (bs_start),
    .data_size (data_size)
);

// File: tb/tb_cfg_hdr_parser.sv
module tb_cfg_hdr_parser;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int SW         = hdr_pkg::SIZE_W;

    typedef struct packed {
        logic [7:0]  hs;
        logic [31:0] bs;
        logic [31:0] cst;
        logic [15:0] ncomp;
        logic [7:0]  seed;
        logic        gap;
        logic        err;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd64, 32'd700,  32'd100,  16'd5,  8'd3,  1'b0, 1'b0},
        '{8'd80, 32'd900,  32'd200,  16'd40, 8'd17, 1'b1, 1'b0},
        '{8'd60, 32'd1023, 32'd300,  16'd1,  8'd99, 1'b0, 1'b0},
        '{8'd70, 32'd1024, 32'd300,  16'd2,  8'd5,  1'b0, 1'b1},
        '{8'd70, 32'd500,  32'd1100, 16'd0,  8'd1,  1'b0, 1'b1},
        '{8'd90, 32'd600,  32'd120,  16'd0,  8'd2,  1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [7:0]    in_data;
    logic          in_ready;
    logic [31:0]   bs_start;
    logic [SW-1:0] data_size;
    logic          done;
    logic          error;

    int checks = 0;
    int errors = 0;

    logic [7:0]  img [DEPTH];
    longint      exp_size;
    logic        r_ok;
    logic        r_err;
    logic [31:0] r_bs;
    logic [SW-1:0] r_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_parser #(.DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .bs_start  (bs_start),
        .data_size (data_size),
        .done      (done),
        .error     (error)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] comp_size(input int seed, input int i);
        int v;
        v = (i + 1) * 40503 + seed * 977 + i * i * 7919;
        if (i % 2 == 1) v = v ^ 32'h003F_0000;
        return v[21:0];
    endfunction

    task automatic clear_img();
        for (int a = 0; a < DEPTH; a++) img[a] = 8'h00;
    endtask

    task automatic put(input int a, input logic [7:0] v);
        if (a >= 0 && a < DEPTH) img[a] = v;
    endtask

    task automatic put_rec(input int hs, input int k, input int tag, input logic [31:0] off);
        int b;
        b = hs + 9 * k;
        put(b, 8'(tag));
        for (int j = 0; j < 4; j++) put(b + 1 + j, off[j*8 +: 8]);
    endtask

    task automatic build_base(input int hs, input int nrec, input int ncomp,
                              input int cst, input int seed);
        logic [21:0] sz;
        int bp;
        clear_img();
        put(24, 8'(hs));
        put(hs - 1, 8'(nrec));
        put(55, 8'(ncomp));
        put(56, 8'(ncomp >> 8));
        exp_size = 0;
        for (int i = 0; i < ncomp; i++) begin
            sz = comp_size(seed, i);
            exp_size += 64'(sz) * 16;
            for (int b = 0; b < 22; b++) begin
                bp = i * 22 + b;
                if (cst + bp / 8 < DEPTH) img[cst + bp / 8][bp % 8] = sz[b];
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic stream(input bit gap, input string req);
        int idx;
        bit fire;
        idx = 0;
        fire = 1'b0;
        r_ok = 1'b0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (fire) idx++;
            if (done) begin
                r_ok = 1'b1;
                r_err = error;
                r_bs = bs_start;
                r_size = data_size;
                break;
            end
            in_valid = (idx < DEPTH) && !(gap && cyc[0]);
            in_data = (idx < DEPTH) ? img[idx] : 8'h00;
            fire = in_valid && in_ready;
        end
        in_valid = 1'b0;
        check(r_ok, req, "completion pulse seen", longint'(r_ok), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R10 reset state
        check(done == 1'b0, "R10", "done after reset", longint'(done), 0);
        check(error == 1'b0, "R10", "error after reset", longint'(error), 0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", longint'(in_ready), 1);
        check(bs_start == 0 && data_size == 0, "R10", "results after reset",
              longint'(bs_start), 0);

        // Table walk: R2/R3 offsets, R5/R6 sizes, R7 bounds, R11 gaps
        for (int v = 0; v < NV; v++) begin
            build_base(int'(VECS[v].hs), 3, int'(VECS[v].ncomp), int'(VECS[v].cst),
                       int'(VECS[v].seed));
            put_rec(int'(VECS[v].hs), 0, 3, 32'h1234_5678);
            put_rec(int'(VECS[v].hs), 1, 8, VECS[v].bs);
            put_rec(int'(VECS[v].hs), 2, 5, VECS[v].cst);
            do_reset();
            stream(VECS[v].gap, "R11");
            check(r_err == VECS[v].err, "R7", $sformatf("vector %0d error flag", v),
                  longint'(r_err), longint'(VECS[v].err));
            if (!VECS[v].err) begin
                check(r_bs == VECS[v].bs, "R2", $sformatf("vector %0d bs_start", v),
                      longint'(r_bs), longint'(VECS[v].bs));
                check(longint'(r_size) == exp_size, "R6",
                      $sformatf("vector %0d data_size (R5 when count 0)", v),
                      longint'(r_size), exp_size);
            end
        end

        // R4: tag 5 never present
        build_base(64, 3, 2, 100, 4);
        put_rec(64, 0, 3, 32'd10);
        put_rec(64, 1, 8, 32'd500);
        put_rec(64, 2, 7, 32'd100);
        do_reset();
        stream(1'b0, "R4");
        check(r_err == 1'b1, "R4", "missing tag error", longint'(r_err), 1);

        // R3: both tags found first, record count runs past the buffer
        build_base(64, 200, 3, 400, 9);
        put_rec(64, 0, 5, 32'd400);
        put_rec(64, 1, 8, 32'd800);
        do_reset();
        stream(1'b0, "R3");
        check(r_err == 1'b0, "R3", "early stop no error", longint'(r_err), 0);
        check(r_bs == 32'd800, "R3", "early stop bs_start", longint'(r_bs), 800);
        check(longint'(r_size) == exp_size, "R3", "early stop data_size",
              longint'(r_size), exp_size);

        // R1: header length zero
        build_base(0, 0, 0, 0, 0);
        do_reset();
        stream(1'b0, "R1");
        check(r_err == 1'b1, "R1", "zero header length error", longint'(r_err), 1);

        // R8: record walk runs beyond the buffer; then R9 hold behaviour
        build_base(64, 120, 1, 100, 1);
        for (int k = 0; k < 107; k++) put_rec(64, k, 3, 32'd0);
        do_reset();
        stream(1'b0, "R8");
        check(r_err == 1'b1, "R8", "out-of-buffer record error", longint'(r_err), 1);
        @(negedge clk);
        check(done == 1'b0, "R9", "done is one cycle", longint'(done), 0);
        check(in_ready == 1'b0, "R9", "in_ready low after done", longint'(in_ready), 0);
        repeat (5) @(negedge clk);
        check(error == 1'b1, "R9", "error held", longint'(error), 1);
        check(bs_start == r_bs && data_size == r_size, "R9", "results held",
              longint'(data_size), longint'(r_size));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule